// File: doc/BRIEF.md
# Buddy block allocator

This block hands out and takes back blocks of pages from a pool of 2^PAGE_BITS pages. Every block holds 2^k pages, with k from 0 to NUM_ORDERS-1, and its base page index is always a multiple of its own size. An allocation request names an order. The allocator finds the smallest free block that is large enough. If that block is too big, it halves it over several cycles, and each upper half it does not use goes back on the free list of its order. The allocator then returns the base page index of the block, or raises a failure flag when no block is large enough.

A free request gives a base index and an order. The allocator compares the freed block with its buddy, which is the block of the same order whose base differs only in bit k. If that buddy is free, the two fuse into one block of order k+1. The check repeats one order higher each time, until a buddy is in use or the top order is reached.

Free state is kept as one bitmap per order, and each bit is indexed by the base index shifted right by the order. A single requester drives the block. A request is taken only while `busy_o` is low, and every accepted request ends with a one-cycle `done_o` pulse.

Top module: `buddy_alloc`

## Requirements
- R1: After reset the whole pool is free as blocks of the top order NUM_ORDERS-1. `busy_o` and `done_o` are low.
- R2: An allocation uses the smallest order, at or above the requested order, that holds a free block. Within that order it takes the free block with the lowest base index.
- R3: When the chosen block is larger than requested, it is halved down to the requested order. The lower half is kept each time, and each upper half becomes a free block of its order, ready for later allocations.
- R4: A successful allocation of order k returns a base index `base_o` whose low k bits are zero.
- R5: If no free block exists at or above the requested order, the allocation completes with `fail_o`=1 and `base_o`=0, and the free state stays unchanged.
- R6: A freed block of order k merges with its buddy if that buddy is free. Merging repeats upward. On completion of a free, `base_o` gives the base of the final merged block and `fail_o` is 0.
- R7: The buddy of the order-k block at base b is the order-k block at base b XOR 2^k.
- R8: Merging never goes past order NUM_ORDERS-1. A free top-order block stays a separate block.
- R9: `alloc_req_i` and `free_req_i` are accepted only in a cycle where `busy_o` is low. A request raised while `busy_o` is high has no effect. If both are raised together, the allocation is taken.
- R10: `busy_o` is high from the cycle after acceptance until completion. Each accepted request produces exactly one `done_o` pulse, one cycle wide, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Allocation request, one-cycle pulse |
| free_req_i | input | 1 | Free request, one-cycle pulse |
| order_i | input | $clog2(NUM_ORDERS) | Order of the request |
| base_i | input | PAGE_BITS | Base page index of the block being freed |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Completion pulse |
| fail_o | output | 1 | Allocation found no block; valid with and after done_o |
| base_o | output | PAGE_BITS | Allocated base, or merged base after a free |

## Verification
The assertions rely on the requester. Each free must name a block that is allocated at the time, with a base aligned to its order. Every order must be below NUM_ORDERS. With those inputs a double free or a misaligned base cannot happen, so the checker does not look for either case.

The stimulus frees only blocks that an earlier allocation returned, and each of them only once. It issues each request as a single-cycle pulse while `busy_o` is low. The one exception is a deliberate request pulsed during a busy split, which the bench then shows had no effect.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_SPLIT,
    ST_MERGE
  } buddy_state_e;
endpackage

// File: rtl/buddy_lowest.sv
module buddy_lowest #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/buddy_free_map.sv
module buddy_free_map #(
  parameter int PAGE_BITS  = 4,
  parameter int NUM_ORDERS = 5,
  localparam int NPAGES    = 1 << PAGE_BITS,
  localparam int ORD_W     = (NUM_ORDERS > 1) ? $clog2(NUM_ORDERS) : 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                set_en_i,
  input  logic [ORD_W-1:0]                    set_ord_i,
  input  logic [PAGE_BITS-1:0]                set_idx_i,
  input  logic                                clr_en_i,
  input  logic [ORD_W-1:0]                    clr_ord_i,
  input  logic [PAGE_BITS-1:0]                clr_idx_i,
  output logic [NUM_ORDERS-1:0][NPAGES-1:0]   map_o
);
  localparam int TOP     = NUM_ORDERS - 1;
  localparam int TOP_CNT = NPAGES >> TOP;
  localparam logic [NPAGES-1:0] TOP_INIT = {NPAGES{1'b1}} >> (NPAGES - TOP_CNT);

  logic [NUM_ORDERS-1:0][NPAGES-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q      <= '0;
      map_q[TOP] <= TOP_INIT;
    end else begin
      if (set_en_i) map_q[set_ord_i][set_idx_i] <= 1'b1;
      if (clr_en_i) map_q[clr_ord_i][clr_idx_i] <= 1'b0;
    end
  end

  assign map_o = map_q;
endmodule

// File: rtl/buddy_pick.sv
module buddy_pick #(
  parameter int PAGE_BITS  = 4,
  parameter int NUM_ORDERS = 5,
  localparam int ORD_W     = (NUM_ORDERS > 1) ? $clog2(NUM_ORDERS) : 1
) (
  input  logic [NUM_ORDERS-1:0]                any_i,
  input  logic [NUM_ORDERS-1:0][PAGE_BITS-1:0] idx_i,
  input  logic [ORD_W-1:0]                     req_ord_i,
  output logic                                 hit_o,
  output logic [ORD_W-1:0]                     hit_ord_o,
  output logic [PAGE_BITS-1:0]                 hit_idx_o
);
  // descending scan: the last match written is the smallest eligible order
  always_comb begin
    hit_o     = 1'b0;
    hit_ord_o = '0;
    hit_idx_o = '0;
    for (int k = NUM_ORDERS - 1; k >= 0; k--) begin
      if (ORD_W'(k) >= req_ord_i && any_i[k]) begin
        hit_o     = 1'b1;
        hit_ord_o = ORD_W'(k);
        hit_idx_o = idx_i[k];
      end
    end
  end
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
  import buddy_pkg::*;
#(
  parameter int PAGE_BITS  = 4,
  parameter int NUM_ORDERS = 5,
  localparam int NPAGES    = 1 << PAGE_BITS,
  localparam int ORD_W     = (NUM_ORDERS > 1) ? $clog2(NUM_ORDERS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alloc_req_i,
  input  logic                 free_req_i,
  input  logic [ORD_W-1:0]     order_i,
  input  logic [PAGE_BITS-1:0] base_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 fail_o,
  output logic [PAGE_BITS-1:0] base_o
);
  localparam logic [ORD_W-1:0]     TOP_ORD = ORD_W'(NUM_ORDERS - 1);
  localparam logic [PAGE_BITS-1:0] ONE_PG  = PAGE_BITS'(1);

  buddy_state_e           state_q;
  logic [ORD_W-1:0]       req_ord_q, cur_ord_q;
  logic [PAGE_BITS-1:0]   cur_base_q, base_q;
  logic                   fail_q, done_q;

  logic [NUM_ORDERS-1:0][NPAGES-1:0]    map;
  logic [NUM_ORDERS-1:0]                ord_any;
  logic [NUM_ORDERS-1:0][PAGE_BITS-1:0] ord_idx;
  logic                                 hit;
  logic [ORD_W-1:0]                     hit_ord;
  logic [PAGE_BITS-1:0]                 hit_idx, hit_base;

  logic                 set_en, clr_en;
  logic [ORD_W-1:0]     set_ord, clr_ord;
  logic [PAGE_BITS-1:0] set_idx, clr_idx;

  logic [ORD_W-1:0]     lo_ord;
  logic [PAGE_BITS-1:0] bud_idx;
  logic                 bud_free;

  buddy_free_map #(.PAGE_BITS(PAGE_BITS), .NUM_ORDERS(NUM_ORDERS)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (set_en),
    .set_ord_i(set_ord),
    .set_idx_i(set_idx),
    .clr_en_i (clr_en),
    .clr_ord_i(clr_ord),
    .clr_idx_i(clr_idx),
    .map_o    (map)
  );

  for (genvar k = 0; k < NUM_ORDERS; k++) begin : g_ord
    buddy_lowest #(.W(NPAGES), .IW(PAGE_BITS)) u_low (
      .vec_i(map[k]),
      .any_o(ord_any[k]),
      .idx_o(ord_idx[k])
    );
  end

  buddy_pick #(.PAGE_BITS(PAGE_BITS), .NUM_ORDERS(NUM_ORDERS)) u_pick (
    .any_i    (ord_any),
    .idx_i    (ord_idx),
    .req_ord_i(req_ord_q),
    .hit_o    (hit),
    .hit_ord_o(hit_ord),
    .hit_idx_o(hit_idx)
  );

  assign hit_base = hit_idx << hit_ord;
  assign lo_ord   = cur_ord_q - ORD_W'(1);
  assign bud_idx  = (cur_base_q >> cur_ord_q) ^ ONE_PG;
  assign bud_free = (cur_ord_q != TOP_ORD) && map[cur_ord_q][bud_idx];

  // bitmap updates: at most one per cycle
  always_comb begin
    set_en  = 1'b0;
    set_ord = '0;
    set_idx = '0;
    clr_en  = 1'b0;
    clr_ord = '0;
    clr_idx = '0;
    unique case (state_q)
      ST_SEARCH: if (hit) begin
        clr_en  = 1'b1;
        clr_ord = hit_ord;
        clr_idx = hit_idx;
      end
      ST_SPLIT: begin
        set_en  = 1'b1;
        set_ord = lo_ord;
        set_idx = (cur_base_q >> lo_ord) | ONE_PG;
      end
      ST_MERGE: begin
        if (bud_free) begin
          clr_en  = 1'b1;
          clr_ord = cur_ord_q;
          clr_idx = bud_idx;
        end else begin
          set_en  = 1'b1;
          set_ord = cur_ord_q;
          set_idx = cur_base_q >> cur_ord_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      req_ord_q  <= '0;
      cur_ord_q  <= '0;
      cur_base_q <= '0;
      base_q     <= '0;
      fail_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (alloc_req_i) begin
            req_ord_q <= order_i;
            state_q   <= ST_SEARCH;
          end else if (free_req_i) begin
            cur_base_q <= base_i;
            cur_ord_q  <= order_i;
            state_q    <= ST_MERGE;
          end
        end
        ST_SEARCH: begin
          if (!hit) begin
            fail_q  <= 1'b1;
            base_q  <= '0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cur_ord_q  <= hit_ord;
            cur_base_q <= hit_base;
            if (hit_ord == req_ord_q) begin
              fail_q  <= 1'b0;
              base_q  <= hit_base;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_SPLIT;
            end
          end
        end
        ST_SPLIT: begin
          cur_ord_q <= lo_ord;
          if (lo_ord == req_ord_q) begin
            fail_q  <= 1'b0;
            base_q  <= cur_base_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_MERGE: begin
          if (bud_free) begin
            cur_base_q <= cur_base_q & ~(ONE_PG << cur_ord_q);
            cur_ord_q  <= cur_ord_q + ORD_W'(1);
          end else begin
            fail_q  <= 1'b0;
            base_q  <= cur_base_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;
  assign base_o = base_q;
endmodule

// File: rtl/buddy_alloc_chk.sv
module buddy_alloc_chk #(
  parameter int PAGE_BITS  = 4,
  parameter int NUM_ORDERS = 5,
  localparam int ORD_W     = (NUM_ORDERS > 1) ? $clog2(NUM_ORDERS) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 alloc_req_i,
  input logic                 free_req_i,
  input logic [ORD_W-1:0]     order_i,
  input logic                 busy_o,
  input logic                 done_o,
  input logic                 fail_o,
  input logic [PAGE_BITS-1:0] base_o
);
  logic             op_alloc_q;
  logic [ORD_W-1:0] op_ord_q;
  logic             accept;

  assign accept = !busy_o && (alloc_req_i || free_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_alloc_q <= 1'b0;
      op_ord_q   <= '0;
    end else if (accept) begin
      op_alloc_q <= alloc_req_i;
      op_ord_q   <= order_i;
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_accept_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);

  assert_base_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_alloc_q && !fail_o) |->
      ((base_o & ((PAGE_BITS'(1) << op_ord_q) - PAGE_BITS'(1))) == '0));

  assert_fail_only_alloc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fail_o) |-> (op_alloc_q && base_o == '0));
endmodule

bind buddy_alloc buddy_alloc_chk #(.PAGE_BITS(PAGE_BITS), .NUM_ORDERS(NUM_ORDERS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alloc_req_i(alloc_req_i),
  .free_req_i (free_req_i),
  .order_i    (order_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fail_o     (fail_o),
  .base_o     (base_o)
);

// File: tb/buddy_alloc_bench.sv
module buddy_alloc_bench;
  localparam int PB = 4;
  localparam int NO = 5;
  localparam int OW = $clog2(NO);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          alloc_req = 1'b0;
  logic          free_req = 1'b0;
  logic [OW-1:0] order = '0;
  logic [PB-1:0] base = '0;
  logic          busy, done, fail;
  logic [PB-1:0] base_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic          exp_fail_q[$];
  logic [PB-1:0] exp_base_q[$];
  string         exp_tag_q[$];

  always #10 clk = ~clk;

  buddy_alloc #(.PAGE_BITS(PB), .NUM_ORDERS(NO)) u_buddy_alloc (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .alloc_req_i(alloc_req),
    .free_req_i (free_req),
    .order_i    (order),
    .base_i     (base),
    .busy_o     (busy),
    .done_o     (done),
    .fail_o     (fail),
    .base_o     (base_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_ni && done) begin
      check(!busy, "R10 busy low at done", int'(busy), 0);
      if (exp_tag_q.size() == 0) begin
        check(1'b0, "R10 unexpected done", 1, 0);
      end else begin
        logic          ef;
        logic [PB-1:0] eb;
        string         t;
        ef = exp_fail_q.pop_front();
        eb = exp_base_q.pop_front();
        t  = exp_tag_q.pop_front();
        check(fail == ef, {t, " fail"}, int'(fail), int'(ef));
        check(base_out == eb, {t, " base"}, int'(base_out), int'(eb));
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic push(input logic f, input logic [PB-1:0] b, input string t);
    exp_fail_q.push_back(f);
    exp_base_q.push_back(b);
    exp_tag_q.push_back(t);
  endtask

  task automatic do_alloc(input int ord, input logic f, input int b, input string t);
    push(f, PB'(b), t);
    order     = OW'(ord);
    alloc_req = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0;
    check(busy, "R10 busy after accept", int'(busy), 1);
    wait_done();
  endtask

  task automatic do_free(input int b, input int ord, input int mb, input string t);
    push(1'b0, PB'(mb), t);
    order    = OW'(ord);
    base     = PB'(b);
    free_req = 1'b1;
    @(negedge clk);
    free_req = 1'b0;
    check(busy, "R10 busy after accept", int'(busy), 1);
    wait_done();
  endtask

  task automatic summary();
    check(exp_tag_q.size() == 0, "R10 missing done", exp_tag_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1 reset idle", int'(busy) + int'(done), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 idle after reset", int'(busy) + int'(done), 0);

    // R1 R3: one top block, split down to a single page
    do_alloc(0, 1'b0, 0, "R3 split to order 0");
    do_alloc(0, 1'b0, 1, "R3 upper half order 0");
    do_alloc(1, 1'b0, 2, "R3 upper half order 1");
    do_alloc(3, 1'b0, 8, "R2 order 3 exact");
    do_alloc(3, 1'b1, 0, "R5 no order 3 left");
    do_alloc(2, 1'b0, 4, "R5 state unchanged, order 2");
    do_alloc(0, 1'b1, 0, "R5 pool full");
    // R7: buddy of page 1 is page 0, still in use
    do_free(1, 0, 1, "R7 buddy busy no merge");
    do_alloc(0, 1'b0, 1, "R7 freed page reused");
    do_free(0, 0, 0, "R6 free page 0");
    do_free(1, 0, 0, "R6 merge to order 1");
    do_free(2, 1, 0, "R6 merge to order 2");
    do_free(4, 2, 0, "R6 merge to order 3");
    do_free(8, 3, 0, "R8 merge to top");
    do_alloc(4, 1'b0, 0, "R8 whole pool");
    do_alloc(0, 1'b1, 0, "R5 nothing after whole pool");
    do_free(0, 4, 0, "R8 top block stays single");

    // R9: free pulsed while busy is ignored
    push(1'b0, PB'(0), "R9 alloc with ignored free");
    order     = OW'(0);
    alloc_req = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0;
    check(busy, "R9 busy during split", int'(busy), 1);
    base     = PB'(8);
    order    = OW'(3);
    free_req = 1'b1;
    @(negedge clk);
    free_req = 1'b0;
    wait_done();
    do_alloc(2, 1'b0, 4, "R2 lowest order 2");
    do_alloc(3, 1'b0, 8, "R9 order 3 still free once");
    do_alloc(3, 1'b1, 0, "R9 no phantom order 3");
    do_alloc(1, 1'b0, 2, "R2 order 1");
    do_alloc(0, 1'b0, 1, "R2 order 0");
    do_alloc(0, 1'b1, 0, "R5 full again");

    // R9: both requests together, allocation wins
    push(1'b1, PB'(0), "R9 alloc priority");
    order     = OW'(0);
    base      = PB'(0);
    alloc_req = 1'b1;
    free_req  = 1'b1;
    @(negedge clk);
    alloc_req = 1'b0;
    free_req  = 1'b0;
    wait_done();

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end
endmodule